// File: doc/BRIEF.md
# Rotating 8-PSK Symbol Mapper

The mapper takes a serial bit stream and turns each group of three bits into a phase index on a 16-point circle. The first bit of a group is the most significant bit of the symbol. Each 3-bit symbol is Gray-decoded to one of eight even base phases. A rotation term is added to that base phase, and the rotation grows by three sixteenths of a turn (3π/8) with every symbol that is issued.

The result is a 4-bit phase index with π/8 resolution, paired with a one-cycle strobe at symbol rate. A lookup stage further down the chain turns the index into I/Q amplitudes. An active-low asynchronous reset returns the whole block to its start state. A synchronous clear input drops a partly assembled symbol and restarts the rotation from zero, so bursts can be aligned without a full reset.

Top module: `psk8_rot_mapper`

## Requirements
- R1: Bits are taken only in cycles where `bit_vld_i` is 1. The first accepted bit of a group is bit 2 (MSB) of the 3-bit symbol, and the third accepted bit is bit 0.
- R2: The base phase is twice the Gray-decoded symbol value. Symbol to base phase: 000→0, 001→2, 011→4, 010→6, 110→8, 111→10, 101→12, 100→14.
- R3: The rotation term is 0 for the first symbol after reset or clear. It rises by 3 (mod 16) after each issued symbol and is unchanged otherwise.
- R4: `phase_o` equals (base phase + rotation term) mod 16, using the rotation term in effect when the symbol completed.
- R5: `sym_vld_o` is high for exactly the one cycle after the clock edge that accepted the third bit of a group. In every other cycle it is low, and `phase_o` keeps its last value.
- R6: While `rst_ni` is low, `phase_o` and `sym_vld_o` are 0. After release, the bit count and the rotation restart from zero.
- R7: When `clr_i` is 1 at a clock edge, the bit count and the rotation go to zero. Any bit presented in that cycle is discarded, and `sym_vld_o` is 0 in the following cycle.
- R8: The rotation term repeats with a period of 16 symbols, so symbol 17 after a restart again uses rotation 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of bit count and rotation |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| phase_o | output | 4 | Rotated phase index, π/8 per step |
| sym_vld_o | output | 1 | One-cycle strobe marking a new `phase_o` |

## Verification
The bench builds the block with its default parameters: 3-bit symbols, a 16-point phase circle and a rotation step of 3. Because 3 and 16 share no factor, every rotation value is reached within sixteen symbols. The wrap back to zero therefore falls inside one short run. All eight symbol codes appear against rotations that differ from one another. This exposes any swap in the Gray table and any carry error in the modulo-16 sum.

// File: rtl/psk8_pkg.sv
package psk8_pkg;
  localparam int unsigned SYM_W_DEF    = 3;
  localparam int unsigned ROT_STEP_DEF = 3;
endpackage

// File: rtl/psk8_bit_gather.sv
module psk8_bit_gather #(
  parameter int unsigned SYM_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = (SYM_W > 2) ? $clog2(SYM_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SYM_W-2:0] sr_q;
  logic             take;

  assign take   = bit_vld_i && !clr_i;
  assign done_o = take && (cnt_q == LAST);
  assign sym_o  = {sr_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (take) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      sr_q  <= {sr_q[SYM_W-3:0], bit_i};
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/psk8_gray_base.sv
module psk8_gray_base #(
  parameter int unsigned SYM_W = 3
) (
  input  logic [SYM_W-1:0] sym_i,
  output logic [SYM_W:0]   base_o
);
  logic [SYM_W-1:0] bin;

  // Gray decode: each binary bit is the XOR of all Gray bits at and above it
  for (genvar i = 0; i < SYM_W; i++) begin : g_dec
    assign bin[i] = ^sym_i[SYM_W-1:i];
  end

  assign base_o = {bin, 1'b0};
endmodule

// File: rtl/psk8_rot_accum.sv
module psk8_rot_accum #(
  parameter int unsigned PH_W     = 4,
  parameter int unsigned ROT_STEP = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  output logic [PH_W-1:0] rot_o
);
  localparam logic [PH_W-1:0] STEP = PH_W'(ROT_STEP);

  logic [PH_W-1:0] rot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rot_q <= '0;
    else if (clr_i)  rot_q <= '0;
    else if (adv_i)  rot_q <= rot_q + STEP;
  end

  assign rot_o = rot_q;

  // R3
  rot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(rot_q));
endmodule

// File: rtl/psk8_rot_mapper.sv
module psk8_rot_mapper
  import psk8_pkg::*;
#(
  parameter int unsigned SYM_W    = SYM_W_DEF,
  parameter int unsigned ROT_STEP = ROT_STEP_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_i,
  input  logic bit_vld_i,
  output logic [SYM_W:0] phase_o,
  output logic sym_vld_o
);
  localparam int unsigned PH_W = SYM_W + 1;

  logic [SYM_W-1:0] sym;
  logic             done;
  logic [PH_W-1:0]  base;
  logic [PH_W-1:0]  rot;
  logic [PH_W-1:0]  phase_q;
  logic             vld_q;

  psk8_bit_gather #(.SYM_W(SYM_W)) i_gather (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .bit_i     (bit_i),
    .bit_vld_i (bit_vld_i),
    .sym_o     (sym),
    .done_o    (done)
  );

  psk8_gray_base #(.SYM_W(SYM_W)) i_base (
    .sym_i  (sym),
    .base_o (base)
  );

  psk8_rot_accum #(.PH_W(PH_W), .ROT_STEP(ROT_STEP)) i_rot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .adv_i  (done),
    .rot_o  (rot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= done;
      if (done) phase_q <= base + rot;  // wraps mod 2**PH_W
    end
  end

  assign phase_o   = phase_q;
  assign sym_vld_o = vld_q;

  // R5
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> !sym_vld_o);

  // R5
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_vld_o |-> $stable(phase_o) || $past(!rst_ni));

  // R7
  clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sym_vld_o);
endmodule

// File: tb/test_psk8_rot_mapper.sv
`timescale 1ns/1ps
module test_psk8_rot_mapper;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic [3:0] phase_o;
  logic       sym_vld_o;

  int n_chk = 0;
  int n_err = 0;
  int rot_k = 0;

  always #4 clk_i = ~clk_i;

  psk8_rot_mapper i_psk8_rot_mapper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .bit_i     (bit_i),
    .bit_vld_i (bit_vld_i),
    .phase_o   (phase_o),
    .sym_vld_o (sym_vld_o)
  );

  // {symbol, expected phase} for symbols 0..7 with rotations 0,3,6,...
  localparam logic [6:0] VEC [8] = '{
    {3'd0, 4'd0},  {3'd1, 4'd5},  {3'd2, 4'd12}, {3'd3, 4'd13},
    {3'd4, 4'd10}, {3'd5, 4'd11}, {3'd6, 4'd10}, {3'd7, 4'd15}
  };

  function automatic int base_of(input logic [2:0] s);
    case (s)
      3'b000: return 0;  3'b001: return 2;  3'b011: return 4;  3'b010: return 6;
      3'b110: return 8;  3'b111: return 10; 3'b101: return 12; default: return 14;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_sym(input logic [2:0] s, input int gap, input int exp_ph,
                          input string req);
    int prev;
    for (int i = 2; i >= 0; i--) begin
      @(negedge clk_i);
      bit_vld_i = 1'b1;
      bit_i = s[i];
      if (i != 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk_i);
          bit_vld_i = 1'b0;
          bit_i = ~bit_i;
          prev = phase_o;
          chk("R5 idle strobe", sym_vld_o, 0);
        end
      end
    end
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    chk({req, " strobe"}, sym_vld_o, 1);
    chk({req, " phase"}, phase_o, exp_ph);
    rot_k = (rot_k + 3) % 16;
    @(negedge clk_i);
    chk("R5 strobe width", sym_vld_o, 0);
    chk("R5 phase hold", phase_o, exp_ph);
  endtask

  initial begin
    #800000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R6 reset state
    repeat (3) @(negedge clk_i);
    chk("R6 phase in reset", phase_o, 0);
    chk("R6 strobe in reset", sym_vld_o, 0);
    rst_ni = 1'b1;

    // R1 R2 R3 R4 vector walk
    for (int v = 0; v < 8; v++)
      send_sym(VEC[v][6:4], 0, int'(VEC[v][3:0]), "R4 table");

    // R5 gaps between bits; model continues from rot_k
    for (int s = 0; s < 8; s++)
      send_sym(3'(s), 2, (base_of(3'(s)) + rot_k) % 16, "R1 gapped");

    // R7 clear mid-symbol with a bit in the clear cycle
    @(negedge clk_i); bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk_i); bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0; bit_vld_i = 1'b0;
    chk("R7 no strobe after clear", sym_vld_o, 0);
    rot_k = 0;
    send_sym(3'b001, 0, 2, "R7 restart");

    // R8 wrap over 16 symbols of 000 after clear
    @(negedge clk_i); clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
    rot_k = 0;
    for (int k = 0; k < 16; k++)
      send_sym(3'b000, 0, (3 * k) % 16, "R3 rotation");
    send_sym(3'b000, 0, 0, "R8 wrap");

    // R6 async reset mid-symbol
    @(negedge clk_i); bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk_i); bit_vld_i = 1'b0; rst_ni = 1'b0;
    #1;
    chk("R6 phase after reset", phase_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    rot_k = 0;
    send_sym(3'b100, 0, 14, "R6 restart");
    send_sym(3'b110, 0, 11, "R2 second after reset");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule